// File: doc/BRIEF.md
# Accumulator ALU with Registered Condition Flags

This block is the arithmetic core of a small accumulator machine. Each cycle it takes the accumulator byte, a second operand byte and a four-bit operation code. It returns a result byte, a strobe that says whether that byte should be written back to the accumulator, and the condition flags the operation would produce. The datapath from operands to result and next flags is purely combinational.

The flags are zero (Z), subtract (N), half-carry (H) and carry (C). They live in a small register inside the block, and the datapath reads its current flags from that register: carry-in for the carrying forms, C for the carry-complement, and N/H/C for the decimal adjust. The register loads the next-flag value on a rising clock edge only when the flag-load input is high, so the surrounding sequencer decides which cycles commit flags.

All pins are plain control and data signals. The block has no streaming interface and no back-pressure. Fetching operands, the register file and memory belong to the surrounding machine.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry) give result = acc + opnd (+ C for op 1) mod 256 with write strobe high. Z is set when the result is zero, N is cleared, H reports a carry out of bit 3, and C reports a carry out of bit 7.
- R2: Op 2 (subtract) and op 3 (subtract with borrow) give result = acc − opnd (− C for op 3) mod 256 with write strobe high. Z is set when the result is zero, N is set, H is set when the low nibble of acc is smaller than the low nibble of opnd plus borrow-in, and C is set when opnd plus borrow-in exceeds acc.
- R3: Op 7 (compare) produces exactly the flags of op 2 and holds the write strobe low.
- R4: Op 4 (AND) writes acc & opnd. Z follows the result, N is cleared, H is forced to 1 and C is cleared.
- R5: Op 5 (XOR) writes acc ^ opnd and op 6 (OR) writes acc | opnd. Both set Z from the result and clear N, H and C.
- R6: Op 8 (increment) writes acc+1 with N=0 and H set when the low nibble was 0xF. Op 9 (decrement) writes acc−1 with N=1 and H set when the low nibble was 0. Both set Z from the result and leave C at its current value.
- R7: Op 10 (complement) writes ~acc, sets N and H, and keeps Z and C.
- R8: Op 11 clears N and H and sets C. Op 12 clears N and H and inverts C. Both keep Z and hold the write strobe low.
- R9: Op 13 (decimal adjust) with N=0 adds 0x06 when H=1 or the low nibble is above 9. It adds 0x60 and sets C when C=1 or acc is above 0x99; otherwise C is kept. It writes the result, sets Z from it, clears H and keeps N.
- R10: Op 13 with N=1 subtracts 0x06 when H=1 and subtracts 0x60 when C=1. It keeps C and N, clears H, sets Z from the result and writes the result.
- R11: The flag register reads {Z,N,H,C} on bits 3..0. It is all zero while reset is low. It takes the next-flag value on a clock edge only when the flag-load input is high, and holds its value otherwise.
- R12: Ops 14 and 15 are no-ops: the write strobe is low and the next flags equal the current flags. The result byte carries meaning only while the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Commit next flags at the coming edge |
| result_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result should be written to the accumulator |
| flags_next_o | output | 4 | Flags the operation produces, {Z,N,H,C} |
| flags_o | output | 4 | Current registered flags, {Z,N,H,C} |

## Verification
The bench sweeps every operand pair for the two-operand operations with carry-in both clear and set. This catches a half-carry taken from the wrong nibble, a borrow sense reported inverted, or a carry-in ignored by only one of the two carrying forms. The single-operand operations, decimal adjust and the reserved codes run over every accumulator value under all sixteen flag states. A design that lets increment or decrement disturb C, lets complement or the carry operations disturb Z, or adjusts in the wrong direction for N would show a flag miscompare there. Compare is checked to raise no write strobe. The flag register is checked for reset to zero and for holding its value while the load input is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12,
    OP_DAA  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = alu8_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         half_o,
  output logic         carry_o
);
  localparam int unsigned HW = W / 2;
  localparam int unsigned UW = W - HW;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [HW:0]  lo_sum;
  logic [UW:0]  hi_sum;

  // Subtraction is a + ~b + ~borrow; carries out then mean "no borrow".
  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    c_eff   = sub_i ^ cin_i;
    lo_sum  = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
    hi_sum  = {1'b0, a_i[W-1:HW]} + {1'b0, b_eff[W-1:HW]} + {{UW{1'b0}}, lo_sum[HW]};
    sum_o   = {hi_sum[UW-1:0], lo_sum[HW-1:0]};
    half_o  = lo_sum[HW] ^ sub_i;
    carry_o = hi_sum[UW] ^ sub_i;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = alu8_pkg::DATA_W
) (
  input  alu8_pkg::alu_op_e op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      res_o
);
  import alu8_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_CPL:  res_o = ~a_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int unsigned W = alu8_pkg::DATA_W
) (
  input  logic [W-1:0]     a_i,
  input  alu8_pkg::flags_t f_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  localparam int unsigned HW        = W / 2;
  localparam logic [HW-1:0] DIG_MAX = HW'(9);
  localparam logic [HW-1:0] DIG_FIX = HW'(6);
  localparam logic [W-1:0]  BYTE_MAX = {DIG_MAX, DIG_MAX};

  logic         lo_fix;
  logic         hi_fix;
  logic [W-1:0] corr;

  always_comb begin
    if (f_i.n) begin
      lo_fix = f_i.h;
      hi_fix = f_i.c;
    end else begin
      lo_fix = f_i.h || (a_i[HW-1:0] > DIG_MAX);
      hi_fix = f_i.c || (a_i > BYTE_MAX);
    end
    corr    = {(hi_fix ? DIG_FIX : '0), (lo_fix ? DIG_FIX : '0)};
    res_o   = f_i.n ? (a_i - corr) : (a_i + corr);
    carry_o = f_i.n ? f_i.c : hi_fix;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int unsigned W = alu8_pkg::FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));

  // R11
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned DATA_W = alu8_pkg::DATA_W,
  parameter int unsigned OP_W   = alu8_pkg::OP_W,
  parameter int unsigned FLAG_W = alu8_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_we_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic [FLAG_W-1:0] flags_o
);
  import alu8_pkg::*;

  alu_op_e           op;
  flags_t            cur_f;
  flags_t            nxt_f;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic              add_sub;
  logic [DATA_W-1:0] add_sum;
  logic              add_h;
  logic              add_c;
  logic [DATA_W-1:0] log_res;
  logic [DATA_W-1:0] daa_res;
  logic              daa_c;

  assign op    = alu_op_e'(op_i);
  assign cur_f = flags_t'(flags_o);

  // One shared adder serves add, subtract, compare, increment and decrement.
  always_comb begin
    add_b   = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : opnd_i;
    add_cin = ((op == OP_ADC) || (op == OP_SBC)) && cur_f.c;
    add_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (acc_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sub_i  (add_sub),
    .sum_o  (add_sum),
    .half_o (add_h),
    .carry_o(add_c)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .res_o(log_res)
  );

  alu8_daa #(.W(DATA_W)) u_daa (
    .a_i    (acc_i),
    .f_i    (cur_f),
    .res_o  (daa_res),
    .carry_o(daa_c)
  );

  always_comb begin
    nxt_f    = cur_f;
    result_o = acc_i;
    res_we_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        result_o = add_sum;
        res_we_o = (op != OP_CMP);
        nxt_f.z  = (add_sum == '0);
        nxt_f.n  = add_sub;
        nxt_f.h  = add_h;
        nxt_f.c  = add_c;
      end
      OP_INC, OP_DEC: begin
        result_o = add_sum;
        res_we_o = 1'b1;
        nxt_f.z  = (add_sum == '0);
        nxt_f.n  = add_sub;
        nxt_f.h  = add_h;
      end
      OP_AND, OP_XOR, OP_OR: begin
        result_o = log_res;
        res_we_o = 1'b1;
        nxt_f.z  = (log_res == '0);
        nxt_f.n  = 1'b0;
        nxt_f.h  = (op == OP_AND);
        nxt_f.c  = 1'b0;
      end
      OP_CPL: begin
        result_o = log_res;
        res_we_o = 1'b1;
        nxt_f.n  = 1'b1;
        nxt_f.h  = 1'b1;
      end
      OP_SCF, OP_CCF: begin
        nxt_f.n  = 1'b0;
        nxt_f.h  = 1'b0;
        nxt_f.c  = (op == OP_SCF) ? 1'b1 : ~cur_f.c;
      end
      OP_DAA: begin
        result_o = daa_res;
        res_we_o = 1'b1;
        nxt_f.z  = (daa_res == '0);
        nxt_f.h  = 1'b0;
        nxt_f.c  = daa_c;
      end
      default: begin
        nxt_f = cur_f;
      end
    endcase
  end

  assign flags_next_o = nxt_f;

  alu8_flagreg #(.W(FLAG_W)) u_flagreg (
    .clk  (clk),
    .rst_n(rst_n),
    .we_i (flag_we_i),
    .d_i  (flags_next_o),
    .q_o  (flags_o)
  );

  // R3
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> !res_we_o);

  // R4
  and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND) |-> (flags_next_o[1] && !flags_next_o[0] && !flags_next_o[2]));

  // R6
  incdec_keep_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_INC) || (op_i == OP_DEC)) |-> (flags_next_o[0] == flags_o[0]));

  // R7
  cpl_keep_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CPL) |-> ((flags_next_o[3] == flags_o[3]) && (flags_next_o[0] == flags_o[0])));

  // R8
  scf_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SCF) |-> (flags_next_o[0] && !res_we_o));

  // R12
  rsv_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_RSV0) |-> (!res_we_o && (flags_next_o == flags_o)));
endmodule

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'd0;
  logic [7:0] opnd_i = 8'd0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o;
  logic       res_we_o;
  logic [3:0] flags_next_o;
  logic [3:0] flags_o;

  int vectors = 0;
  int misses  = 0;
  logic [3:0] cur_f = 4'd0;

  always #5 clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .flag_we_i(flag_we_i), .result_o(result_o), .res_we_o(res_we_o),
    .flags_next_o(flags_next_o), .flags_o(flags_o)
  );

  // Packing: [12:5] result, [4] write strobe, [3:0] {Z,N,H,C}
  function automatic logic [12:0] ref_model(input int op, input int a, input int b,
                                            input logic [3:0] f);
    int r, k, corr;
    logic z, n, h, c, we;
    z = f[3]; n = f[2]; h = f[1]; c = f[0];
    r = a; we = 1'b0; k = 0; corr = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? int'(c) : 0;
        h = ((a & 15) + (b & 15) + k) > 15;
        r = a + b + k; c = r > 255; r = r & 255;
        z = (r == 0); n = 1'b0; we = 1'b1;
      end
      2, 3, 7: begin
        k = (op == 3) ? int'(c) : 0;
        h = (a & 15) < ((b & 15) + k);
        c = (b + k) > a;
        r = (a - b - k) & 255;
        z = (r == 0); n = 1'b1; we = (op != 7);
      end
      4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; we = 1; end
      5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
      6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
      8: begin h = (a & 15) == 15; r = (a + 1) & 255; z = (r == 0); n = 0; we = 1; end
      9: begin h = (a & 15) == 0; r = (a - 1) & 255; z = (r == 0); n = 1; we = 1; end
      10: begin r = (~a) & 255; n = 1; h = 1; we = 1; end
      11: begin n = 0; h = 0; c = 1; end
      12: begin n = 0; h = 0; c = ~c; end
      13: begin
        if (!n) begin
          if (h || (a & 15) > 9) corr = corr + 6;
          if (c || a > 153) begin corr = corr + 96; c = 1; end
          r = (a + corr) & 255;
        end else begin
          if (h) corr = corr + 6;
          if (c) corr = corr + 96;
          r = (a - corr) & 255;
        end
        z = (r == 0); h = 0; we = 1;
      end
      default: ;
    endcase
    return {r[7:0], we, z, n, h, c};
  endfunction

  function automatic string req_of(input int op, input logic [3:0] f);
    case (op)
      0, 1:   return "R1";
      2, 3:   return "R2";
      7:      return "R3";
      4:      return "R4";
      5, 6:   return "R5";
      8, 9:   return "R6";
      10:     return "R7";
      11, 12: return "R8";
      13:     return f[2] ? "R10" : "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic note(input string tag, input bit ok, input logic [15:0] act,
                      input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h op=%0d acc=%h opnd=%h flags=%b",
               tag, act, exp, op_i, acc_i, opnd_i, cur_f);
    end
  endtask

  function automatic bit find_step(input logic [3:0] from, input logic [3:0] target,
                                   output int fo, output int fa, output int fb);
    logic [7:0] blist [0:9];
    logic [12:0] m;
    blist = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h20, 8'h78, 8'h80, 8'h88, 8'hF0, 8'hFF};
    fo = 0; fa = 0; fb = 0;
    for (int o = 0; o < 14; o++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 11; j++) begin
          int b;
          b = (j == 10) ? a : int'(blist[j]);
          m = ref_model(o, a, b, from);
          if (m[3:0] == target) begin fo = o; fa = a; fb = b; return 1'b1; end
        end
    return 1'b0;
  endfunction

  // R11: commit flags through the normal interface and confirm the register
  task automatic load_step(input int o, input int a, input int b);
    logic [12:0] m;
    @(negedge clk);
    op_i = 4'(o); acc_i = 8'(a); opnd_i = 8'(b); flag_we_i = 1'b1;
    m = ref_model(o, a, b, cur_f);
    @(negedge clk);
    flag_we_i = 1'b0;
    cur_f = m[3:0];
    note("R11 load", flags_o == cur_f, {12'd0, flags_o}, {12'd0, cur_f});
  endtask

  task automatic set_flags(input logic [3:0] target);
    int o, a, b;
    int po [0:4];
    int pa [0:4];
    int pb [0:4];
    logic [3:0] f1;
    bit done;
    po = '{11, 6, 5, 2, 0}; pa = '{0, 1, 0, 0, 128}; pb = '{0, 0, 0, 0, 128};
    done = 1'b0;
    if (find_step(cur_f, target, o, a, b)) begin
      load_step(o, a, b); done = 1'b1;
    end else begin
      for (int p = 0; p < 5 && !done; p++) begin
        logic [12:0] m;
        m = ref_model(po[p], pa[p], pb[p], cur_f);
        f1 = m[3:0];
        if (find_step(f1, target, o, a, b)) begin
          load_step(po[p], pa[p], pb[p]);
          load_step(o, a, b);
          done = 1'b1;
        end
      end
    end
    if (!done) note("R11 reach", 1'b0, {12'd0, cur_f}, {12'd0, target});
  endtask

  task automatic check_vec(input int o, input int a, input int b);
    logic [12:0] m;
    bit ok;
    op_i = 4'(o); acc_i = 8'(a); opnd_i = 8'(b);
    m = ref_model(o, a, b, cur_f);
    #1;
    ok = (res_we_o == m[4]) && (flags_next_o == m[3:0]) && (!m[4] || result_o == m[12:5]);
    note(req_of(o, cur_f), ok, {3'd0, result_o, res_we_o, flags_next_o}, {3'd0, m});
  endtask

  initial begin
    #1_950_000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    note("R11 reset", flags_o == 4'd0, {12'd0, flags_o}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    note("R11 after reset", flags_o == 4'd0, {12'd0, flags_o}, 16'd0);

    // R11 hold: load-enable low across edges leaves flags untouched
    set_flags(4'b0101);
    op_i = 4'd4; acc_i = 8'h00; opnd_i = 8'h00;
    repeat (2) @(negedge clk);
    note("R11 hold", flags_o == 4'b0101, {12'd0, flags_o}, 16'h0005);

    // R1 R2 R3 R4 R5: every operand pair with carry clear, then set
    for (int cv = 0; cv < 2; cv++) begin
      set_flags(cv ? 4'b0001 : 4'b0000);
      for (int o = 0; o < 8; o++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            check_vec(o, a, b);
    end

    // R6 R7 R8 R9 R10 R12: every accumulator under all flag states
    for (int s = 0; s < 16; s++) begin
      set_flags(4'(s));
      for (int o = 8; o < 16; o++)
        for (int a = 0; a < 256; a++)
          check_vec(o, a, a ^ 8'hA5);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule